// File: doc/BRIEF.md
# Serial Command Word Receiver

This block sits on the target side of a four-wire serial link and takes in fixed 16-bit command words from a host. Its three inputs are the serial clock, an active-low select and the serial data line. All three are asynchronous to the local clock. Each one passes through a two-stage synchroniser, and the block finds clock and select edges by oversampling them with the system clock. The serial clock idles low. A data bit is taken on each rising edge of the serial clock while select is low. The host changes data on the falling edge.

A transfer counts only if select returns high after exactly 16 rising serial clock edges. The block then gives a single-cycle valid strobe, together with the 4-bit opcode from the top nibble of the word and the 12-bit operand from the rest. One opcode is reserved as a configuration write. It loads the low bits of the operand into a mode register that the surrounding logic reads directly. A transfer with any other bit count is thrown away without a trace.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `word_vld_o` is 0 and `cfg_o` is 0.
- R2: Bits are shifted in most significant first, one on each rising edge of `sck_i` while `cs_n_i` is low. In a valid transfer, `cmd_o` carries word bits 15..12 and `data_o` carries word bits 11..0.
- R3: For a valid transfer, `word_vld_o` goes high on the third rising `clk` edge after `cs_n_i` goes high, counting the first edge that sees `cs_n_i` high.
- R4: A transfer that ends with fewer than 16 rising `sck_i` edges gives no strobe and leaves `cfg_o` unchanged.
- R5: A transfer that ends with more than 16 rising `sck_i` edges gives no strobe and leaves `cfg_o` unchanged.
- R6: Rising `sck_i` edges while `cs_n_i` is high are not counted. Each select-low period starts counting again from zero.
- R7: A valid word with opcode 4'h1 loads `data_o[7:0]` into `cfg_o` one `clk` edge after the strobe.
- R8: A valid word with any other opcode still gives the strobe, but leaves `cfg_o` unchanged.
- R9: `word_vld_o` is high for exactly one `clk` cycle per valid transfer.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, idles low |
| cs_n_i | input | 1 | Active-low transfer select from the host |
| mosi_i | input | 1 | Serial data from the host |
| word_vld_o | output | 1 | One-cycle strobe for each accepted word |
| cmd_o | output | 4 | Opcode of the last accepted word |
| data_o | output | 12 | Operand of the last accepted word |
| cfg_o | output | 8 | Mode register, loaded by opcode 4'h1 |

## Verification
The bench sends words with all bits set, all bits clear and mixed bit values. This shows whether the order of bits and the split between opcode and operand are correct. Configuration writes are interleaved with words carrying other opcodes, so a register that loads on every strobe shows up as a mismatch. Transfers of 15 and 17 bits carry the configuration opcode, so a wrong length test would both raise a strobe and corrupt the register. Serial clock pulses sent while select is high, followed by an empty select pulse, test whether the bit counter is gated by select and cleared at the start of each transfer.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int FRAME_BITS  = 16;
    localparam int OPCODE_BITS = 4;
    localparam int MODE_BITS   = 8;
    localparam int SYNC_DEPTH  = 2;
    localparam logic [OPCODE_BITS-1:0] MODE_WRITE_OP = 4'h1;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_i;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               cs_n_s,
    input  logic               mosi_s,
    output logic               vld_o,
    output logic [FRAME_W-1:0] word_o
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [FRAME_W-1:0] word;
        logic [CNT_W-1:0]   cnt;
        logic               sck_prev;
        logic               cs_prev;
        logic               vld;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_n_s;
        if (cs_n_s) begin
            st_d.cnt = '0;
            if (!st_q.cs_prev && st_q.cnt == CNT_W'(FRAME_W)) begin
                st_d.vld  = 1'b1;
                st_d.word = st_q.shreg;
            end
        end else if (sck_s && !st_q.sck_prev) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], mosi_s};
            if (st_q.cnt != CNT_W'(CNT_MAX))
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign word_o = st_q.word;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld); // R9
    AST_STROBE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> st_q.cs_prev); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_MAX)); // R5
    AST_COUNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && st_q.cs_prev) |=> st_q.cnt == '0); // R6
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
    parameter int                  FRAME_W = 16,
    parameter int                  OP_W    = 4,
    parameter int                  CFG_W   = 8,
    parameter logic [OP_W-1:0]     CFG_OP  = 4'h1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [FRAME_W-1:0]     word_i,
    output logic [OP_W-1:0]        cmd_o,
    output logic [FRAME_W-OP_W-1:0] data_o,
    output logic [CFG_W-1:0]       cfg_o
);
    localparam int DATA_W = FRAME_W - OP_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } dec_st_t;

    dec_st_t st_d, st_q;

    assign cmd_o  = word_i[FRAME_W-1 -: OP_W];
    assign data_o = word_i[DATA_W-1:0];

    always_comb begin
        st_d = st_q;
        if (vld_i && cmd_o == CFG_OP)
            st_d.cfg = data_o[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(cfg_o)); // R8
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && word_i[FRAME_W-1 -: OP_W] == CFG_OP) |=> cfg_o == $past(word_i[CFG_W-1:0])); // R7
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
    import spi_cmd_pkg::*;
#(
    parameter int                     FRAME_W = FRAME_BITS,
    parameter int                     OP_W    = OPCODE_BITS,
    parameter int                     CFG_W   = MODE_BITS,
    parameter int                     SYNC_N  = SYNC_DEPTH,
    parameter logic [OPCODE_BITS-1:0] CFG_OP  = MODE_WRITE_OP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sck_i,
    input  logic                      cs_n_i,
    input  logic                      mosi_i,
    output logic                      word_vld_o,
    output logic [OP_W-1:0]           cmd_o,
    output logic [FRAME_W-OP_W-1:0]   data_o,
    output logic [CFG_W-1:0]          cfg_o
);
    logic [2:0]         pins_s;
    logic               vld;
    logic [FRAME_W-1:0] word;

    spi_cmd_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sck_i, cs_n_i, mosi_i}),
        .sync_o  (pins_s)
    );

    spi_cmd_frame #(.FRAME_W(FRAME_W)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (pins_s[2]),
        .cs_n_s (pins_s[1]),
        .mosi_s (pins_s[0]),
        .vld_o  (vld),
        .word_o (word)
    );

    spi_cmd_decode #(.FRAME_W(FRAME_W), .OP_W(OP_W), .CFG_W(CFG_W),
                     .CFG_OP(OP_W'(CFG_OP))) i_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld),
        .word_i (word),
        .cmd_o  (cmd_o),
        .data_o (data_o),
        .cfg_o  (cfg_o)
    );

    assign word_vld_o = vld;
endmodule

// File: tb/test_spi_cmd_rx.sv
module test_spi_cmd_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        vld;
    logic [3:0]  cmd;
    logic [11:0] data;
    logic [7:0]  cfg;

    int    n_chk = 0, n_fail = 0;
    bit    mon_on = 1'b0;
    int    v_wait = 0, c_wait = 0;
    logic [15:0] exp_word = '0;
    logic [7:0]  exp_cfg = '0;
    string cur_req = "R2";

    always #10 clk = ~clk;

    spi_cmd_rx i_spi_cmd_rx (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .word_vld_o(vld), .cmd_o(cmd), .data_o(data), .cfg_o(cfg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // reference model, evaluated 5 ns after each rising clock edge
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            bit exp_vld;
            exp_vld = 1'b0;
            if (v_wait > 0) begin
                v_wait--;
                if (v_wait == 0) exp_vld = 1'b1;
            end
            if (c_wait > 0) begin
                c_wait--;
                if (c_wait == 0 && exp_word[15:12] == 4'h1) exp_cfg = exp_word[7:0];
            end
            chk(vld == exp_vld, {cur_req, " R3 R9 strobe"}, int'(vld), int'(exp_vld));
            if (exp_vld) begin
                chk(cmd == exp_word[15:12], "R2 opcode", int'(cmd), int'(exp_word[15:12]));
                chk(data == exp_word[11:0], "R2 operand", int'(data), int'(exp_word[11:0]));
            end
            chk(cfg == exp_cfg, "R7 R8 mode register", int'(cfg), int'(exp_cfg));
        end
    end

    task automatic half_bit();
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        @(negedge clk);
        cs_n = 1'b0;
        half_bit();
        for (int i = n - 1; i >= 0; i--) begin
            mosi = bits[i];
            half_bit();
            sck = 1'b1;
            half_bit();
            sck = 1'b0;
        end
        half_bit();
        cs_n = 1'b1;
        if (n == 16) begin
            exp_word = bits[15:0];
            v_wait = 3;
            c_wait = 4;
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(vld == 1'b0, "R1 strobe in reset", int'(vld), 0);
        chk(cfg == 8'h00, "R1 mode in reset", int'(cfg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vld == 1'b0, "R1 strobe after reset", int'(vld), 0);
        chk(cfg == 8'h00, "R1 mode after reset", int'(cfg), 0);
        mon_on = 1'b1;

        cur_req = "R7"; send(32'h10A5, 16);
        cur_req = "R8"; send(32'h2F3C, 16);
        cur_req = "R2"; send(32'hFFFF, 16);
        cur_req = "R2"; send(32'h0000, 16);
        cur_req = "R7"; send(32'h1F5A, 16);
        cur_req = "R4"; send(32'h1033, 15);
        cur_req = "R5"; send(32'h1_0C3, 17);
        cur_req = "R8"; send(32'hE7B2, 16);
        // clock pulses while deselected, then an empty select pulse
        cur_req = "R6";
        for (int i = 0; i < 16; i++) begin
            half_bit(); sck = 1'b1; half_bit(); sck = 1'b0;
        end
        send(32'h0, 0);
        cur_req = "R6"; send(32'h1C69, 16);

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule